// File: doc/BRIEF.md
# Serial Port Interrupt Identification Unit

This block decides which interrupt a 16550-style serial controller reports and whether its external request line is driven. It watches five kinds of condition: receive errors, received data, a stalled receive queue (character timeout), an empty transmit holding register, and changes on the modem-status lines. It combines them with the per-source enable bits and picks the most urgent one. The result is a 4-bit identification code, presented in the low nibble of an 8-bit read value. The upper bits of that value tell software whether the queues are on and whether the deep queue mode is selected.

Error, modem-change and transmit-empty conditions are held in sticky pending bits. Each one is cleared by the register access that services it: reading the line status, reading the modem status, writing the transmit holding register, or reading the identification value while the transmit-empty source is the one shown. Received-data availability is a level taken straight from the receive queue logic. The character timeout comes from an internal counter of character-time ticks, which restarts whenever a byte arrives or is read. Software reads the identification value again and again until it shows the idle code. Every access therefore takes effect in the value returned by the next read.

Top module: `uart_irq_ident`

## Requirements
- R1: With no enabled source pending, the code (read bits 3:0) is 4'b0001 and the request pin is low.
- R2: When several enabled sources are pending, the order is: line status (4'b0110) first, then received data (4'b0100), then character timeout (4'b1100), then transmit empty (4'b0010), then modem change (4'b0000).
- R3: Enable bit 0 gates received data and timeout, bit 1 gates transmit empty, bit 2 gates line status and bit 3 gates modem change. A source whose enable bit is clear never appears in the code.
- R4: Any nonzero error event sets the line-status pending bit. A line-status read clears it, and an event in the same cycle wins over the read.
- R5: While the receive queue signals data available, the code shows received data from the same cycle on.
- R6: With the queue non-empty, TO_CHARS character ticks with no byte pushed and no byte read raise the timeout. A push, a read, or an empty queue restarts the count.
- R7: Transmit empty becomes pending when the holding register turns empty, or when its enable bit rises while the register is empty. It clears on a holding-register write, or on an identification read while 4'b0010 is shown. A new set event in the same cycle wins over a clear.
- R8: Any nonzero modem-change event sets the modem pending bit. A modem-status read clears it, and an event in the same cycle wins over the read.
- R9: Read bits 7:6 are 2'b11 when the queues are on and 2'b00 when they are off. Bit 5 is 1 only when the queues are on and deep mode is selected. Bit 4 is always 0.
- R10: The request pin is high exactly when the code is not 4'b0001 and auxiliary output 2 is set.
- R11: After reset no source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int_en | input | 4 | Source enables (bit0 rx/timeout, bit1 tx empty, bit2 line, bit3 modem) |
| err_evt | input | ERR_W | One-cycle receive error events |
| rx_avail | input | 1 | Receive data available / trigger level reached |
| rx_nonempty | input | 1 | Receive queue holds at least one byte |
| rx_push | input | 1 | A byte entered the receive queue |
| char_tick | input | 1 | One pulse per character time |
| thr_empty | input | 1 | Transmit holding register empty |
| ms_delta | input | MS_W | One-cycle modem-line change events |
| rd_iir | input | 1 | Identification value being read |
| rd_lsr | input | 1 | Line status being read |
| rd_msr | input | 1 | Modem status being read |
| rd_rbr | input | 1 | Receive buffer being read |
| wr_thr | input | 1 | Transmit holding register being written |
| fifo_on | input | 1 | Queues enabled |
| fifo_deep | input | 1 | Deep queue mode selected |
| aux_out2 | input | 1 | Auxiliary output 2, gates the request pin |
| iir_rd | output | 8 | Identification read value |
| irq | output | 1 | External interrupt request |

## Verification
The read value and the pin are combinational from the pending state. An event or clearing access sampled at a clock edge shows on the outputs right after that edge, so it is visible to a read in the following cycle. Received-data availability shows in the cycle it is raised. The timeout shows just after the edge that takes the TO_CHARS-th tick. The bench drives inputs just after the falling edge and compares both outputs a quarter period later, before the next rising edge. It advances its behavioural model only after that rising edge, using the inputs that were held across it.

// File: rtl/uart_irq_pkg.sv
// Shared definitions for the interrupt identification unit.
// Assumes a 4-bit identification code whose values software decodes.
package uart_irq_pkg;
    typedef enum logic [3:0] {
        IID_MODEM   = 4'b0000,
        IID_NONE    = 4'b0001,
        IID_THRE    = 4'b0010,
        IID_RXDATA  = 4'b0100,
        IID_LINE    = 4'b0110,
        IID_TIMEOUT = 4'b1100
    } iid_e;

    localparam int EN_RX   = 0;
    localparam int EN_THRE = 1;
    localparam int EN_LINE = 2;
    localparam int EN_MS   = 3;
endpackage

// File: rtl/uirq_sticky.sv
// Sticky pending bit: set by any nonzero event vector, cleared by a
// servicing access. Assumes a set and a clear in one cycle keep it set.
module uirq_sticky #(
    parameter int EVT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt,
    input  logic             clr,
    output logic             pend
);
    // Hold the pending state between event and service.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend <= 1'b0;
        else if (|evt)    pend <= 1'b1;
        else if (clr)     pend <= 1'b0;
    end
endmodule

// File: rtl/uirq_timeout.sv
// Character-timeout detector: counts character ticks while the receive
// queue is non-empty and idle. Assumes char_tick is a one-cycle pulse.
module uirq_timeout #(
    parameter  int TO_CHARS = 4,
    localparam int CW       = $clog2(TO_CHARS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_nonempty,
    input  logic          rx_push,
    input  logic          rx_read,
    input  logic          char_tick,
    output logic          to_hit,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] LIMIT = CW'(TO_CHARS);

    // Saturating idle counter, restarted by any receive activity.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   cnt <= '0;
        else if (!rx_nonempty || rx_push || rx_read)  cnt <= '0;
        else if (char_tick && cnt != LIMIT)           cnt <= cnt + 1'b1;
    end

    // Timeout stands while the limit is reached and data remains.
    always_comb to_hit = (cnt == LIMIT) && rx_nonempty;
endmodule

// File: rtl/uirq_thre.sv
// Transmit-empty source: arms on the register turning empty or on its
// enable rising while empty; disarms on a write or an acknowledging read.
module uirq_thre (
    input  logic clk,
    input  logic rst_n,
    input  logic thr_empty,
    input  logic en,
    input  logic thr_write,
    input  logic ack_read,
    output logic pend
);
    logic empty_q;
    logic en_q;
    logic arm;

    // Edge detectors for the empty flag and the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
            en_q    <= 1'b0;
        end else begin
            empty_q <= thr_empty;
            en_q    <= en;
        end
    end

    // Arming condition for this cycle.
    always_comb arm = (thr_empty && !empty_q) || (en && !en_q && thr_empty);

    // Pending state; arming wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n)                      pend <= 1'b0;
        else if (arm)                    pend <= 1'b1;
        else if (thr_write || ack_read)  pend <= 1'b0;
    end
endmodule

// File: rtl/uirq_prio.sv
// Fixed-priority encoder from gated sources to the identification code.
// Assumes all inputs are already settled levels.
module uirq_prio
    import uart_irq_pkg::*;
(
    input  logic [3:0] en,
    input  logic       line_p,
    input  logic       rx_p,
    input  logic       to_p,
    input  logic       thre_p,
    input  logic       ms_p,
    output iid_e       code
);
    // Highest enabled pending source selects the code.
    always_comb begin
        if (en[EN_LINE] && line_p)      code = IID_LINE;
        else if (en[EN_RX] && rx_p)     code = IID_RXDATA;
        else if (en[EN_RX] && to_p)     code = IID_TIMEOUT;
        else if (en[EN_THRE] && thre_p) code = IID_THRE;
        else if (en[EN_MS] && ms_p)     code = IID_MODEM;
        else                            code = IID_NONE;
    end
endmodule

// File: rtl/uart_irq_ident.sv
// Interrupt identification unit for a 16550-style serial controller.
// Collects source conditions, clears them on servicing accesses, and
// reports the most urgent one plus queue-mode bits. Assumes all strobes
// are single-cycle and synchronous to clk.
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int ERR_W    = 4,
    parameter int MS_W     = 4,
    parameter int TO_CHARS = 4,
    localparam int CW      = $clog2(TO_CHARS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       int_en,
    input  logic [ERR_W-1:0] err_evt,
    input  logic             rx_avail,
    input  logic             rx_nonempty,
    input  logic             rx_push,
    input  logic             char_tick,
    input  logic             thr_empty,
    input  logic [MS_W-1:0]  ms_delta,
    input  logic             rd_iir,
    input  logic             rd_lsr,
    input  logic             rd_msr,
    input  logic             rd_rbr,
    input  logic             wr_thr,
    input  logic             fifo_on,
    input  logic             fifo_deep,
    input  logic             aux_out2,
    output logic [7:0]       iir_rd,
    output logic             irq
);
    localparam int NSTICKY = 2;
    localparam int EVW     = (ERR_W > MS_W) ? ERR_W : MS_W;

    logic [NSTICKY-1:0]          st_pend;
    logic [NSTICKY-1:0]          st_clr;
    logic [NSTICKY-1:0][EVW-1:0] st_evt;
    logic                        ls_pend;
    logic                        ms_pend;
    logic                        thre_pend;
    logic                        to_hit;
    logic [CW-1:0]               to_cnt;
    iid_e                        code;

    // Route events and clears to the sticky sources (0 line, 1 modem).
    always_comb begin
        st_evt    = '0;
        st_evt[0] = EVW'(err_evt);
        st_evt[1] = EVW'(ms_delta);
        st_clr    = {rd_msr, rd_lsr};
    end

    generate
        for (genvar g = 0; g < NSTICKY; g++) begin : g_sticky
            uirq_sticky #(.EVT_W(EVW)) u_st (
                .clk  (clk),
                .rst_n(rst_n),
                .evt  (st_evt[g]),
                .clr  (st_clr[g]),
                .pend (st_pend[g])
            );
        end
    endgenerate

    // Name the sticky outputs.
    always_comb begin
        ls_pend = st_pend[0];
        ms_pend = st_pend[1];
    end

    uirq_timeout #(.TO_CHARS(TO_CHARS)) u_to (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_nonempty(rx_nonempty),
        .rx_push    (rx_push),
        .rx_read    (rd_rbr),
        .char_tick  (char_tick),
        .to_hit     (to_hit),
        .cnt        (to_cnt)
    );

    uirq_thre u_thre (
        .clk      (clk),
        .rst_n    (rst_n),
        .thr_empty(thr_empty),
        .en       (int_en[EN_THRE]),
        .thr_write(wr_thr),
        .ack_read (rd_iir && (code == IID_THRE)),
        .pend     (thre_pend)
    );

    uirq_prio u_prio (
        .en    (int_en),
        .line_p(ls_pend),
        .rx_p  (rx_avail),
        .to_p  (to_hit),
        .thre_p(thre_pend),
        .ms_p  (ms_pend),
        .code  (code)
    );

    // Assemble the read value and the gated request pin.
    always_comb begin
        iir_rd = {{2{fifo_on}}, fifo_on & fifo_deep, 1'b0, code};
        irq    = (code != IID_NONE) && aux_out2;
    end
endmodule

// File: rtl/uart_irq_ident_chk.sv
// Property checker for uart_irq_ident, attached by bind.
module uart_irq_ident_chk #(
    parameter  int ERR_W    = 4,
    parameter  int MS_W     = 4,
    parameter  int TO_CHARS = 4,
    localparam int CW       = $clog2(TO_CHARS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       int_en,
    input logic [ERR_W-1:0] err_evt,
    input logic [MS_W-1:0]  ms_delta,
    input logic             thr_empty,
    input logic             rd_lsr,
    input logic             rd_msr,
    input logic             wr_thr,
    input logic             fifo_on,
    input logic             aux_out2,
    input logic [7:0]       iir_rd,
    input logic             irq,
    input logic             ls_pend,
    input logic             ms_pend,
    input logic             thre_pend,
    input logic [CW-1:0]    to_cnt
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd[3:0] == 4'b0001) |-> !irq);
    a_r10_out2_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_out2 |-> !irq);
    a_r2_line_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_pend && int_en[2]) |-> (iir_rd[3:0] == 4'b0110));
    a_r4_lsr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lsr && err_evt == '0) |=> !ls_pend);
    a_r8_msr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_msr && ms_delta == '0) |=> !ms_pend);
    a_r7_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_thr && !thr_empty) |=> !thre_pend);
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        to_cnt <= CW'(TO_CHARS));
    a_r9_fifo_off: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_on |-> (iir_rd[7:4] == 4'b0000));
    a_r11_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!ls_pend && !ms_pend && !thre_pend));
endmodule

bind uart_irq_ident uart_irq_ident_chk #(
    .ERR_W(ERR_W), .MS_W(MS_W), .TO_CHARS(TO_CHARS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .int_en(int_en), .err_evt(err_evt),
    .ms_delta(ms_delta), .thr_empty(thr_empty), .rd_lsr(rd_lsr),
    .rd_msr(rd_msr), .wr_thr(wr_thr), .fifo_on(fifo_on),
    .aux_out2(aux_out2), .iir_rd(iir_rd), .irq(irq), .ls_pend(ls_pend),
    .ms_pend(ms_pend), .thre_pend(thre_pend), .to_cnt(to_cnt)
);

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
    localparam int CLK_P = 10;
    localparam int TO_N  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] int_en = '0;
    logic [3:0] err_evt = '0;
    logic       rx_avail = 0, rx_nonempty = 0, rx_push = 0, char_tick = 0;
    logic       thr_empty = 1'b1;
    logic [3:0] ms_delta = '0;
    logic       rd_iir = 0, rd_lsr = 0, rd_msr = 0, rd_rbr = 0, wr_thr = 0;
    logic       fifo_on = 0, fifo_deep = 0, aux_out2 = 0;
    logic [7:0] iir_rd;
    logic       irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    // reference model state
    bit m_ls, m_ms, m_thre, m_te_q, m_en_q;
    int m_cnt;

    uart_irq_ident #(.ERR_W(4), .MS_W(4), .TO_CHARS(TO_N)) i_uart_irq_ident (
        .clk(clk), .rst_n(rst_n), .int_en(int_en), .err_evt(err_evt),
        .rx_avail(rx_avail), .rx_nonempty(rx_nonempty), .rx_push(rx_push),
        .char_tick(char_tick), .thr_empty(thr_empty), .ms_delta(ms_delta),
        .rd_iir(rd_iir), .rd_lsr(rd_lsr), .rd_msr(rd_msr), .rd_rbr(rd_rbr),
        .wr_thr(wr_thr), .fifo_on(fifo_on), .fifo_deep(fifo_deep),
        .aux_out2(aux_out2), .iir_rd(iir_rd), .irq(irq));

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [3:0] m_code();
        if (int_en[2] && m_ls) return 4'b0110;
        if (int_en[0] && rx_avail) return 4'b0100;
        if (int_en[0] && m_cnt == TO_N && rx_nonempty) return 4'b1100;
        if (int_en[1] && m_thre) return 4'b0010;
        if (int_en[3] && m_ms) return 4'b0000;
        return 4'b0001;
    endfunction

    function automatic string code_tag(logic [3:0] c);
        case (c)
            4'b0110: return "R4";
            4'b0100: return "R5";
            4'b1100: return "R6";
            4'b0010: return "R7";
            4'b0000: return "R8";
            default: return "R1";
        endcase
    endfunction

    // Compare both outputs against the model; tag "" picks one by result.
    task automatic compare(string tag);
        logic [3:0] c = m_code();
        logic [7:0] e = {{2{fifo_on}}, fifo_on & fifo_deep, 1'b0, c};
        logic       ei = (c != 4'b0001) && aux_out2;
        string t1 = (tag != "") ? tag : ((iir_rd[7:4] != e[7:4]) ? "R9" : code_tag(c));
        string t2 = (tag != "") ? tag : "R10";
        n_chk++;
        if (iir_rd !== e) begin
            n_fail++;
            $display("FAIL %s iir actual=%b expected=%b t=%0t", t1, iir_rd, e, $time);
        end
        n_chk++;
        if (irq !== ei) begin
            n_fail++;
            $display("FAIL %s irq actual=%b expected=%b t=%0t", t2, irq, ei, $time);
        end
    endtask

    // Advance the model across one rising edge with the held inputs.
    task automatic m_update();
        logic [3:0] c = m_code();
        bit arm;
        if (!rst_n) begin
            m_ls = 0; m_ms = 0; m_thre = 0; m_te_q = 1; m_en_q = 0; m_cnt = 0;
            return;
        end
        if (err_evt != 0) m_ls = 1; else if (rd_lsr) m_ls = 0;
        if (ms_delta != 0) m_ms = 1; else if (rd_msr) m_ms = 0;
        arm = (thr_empty && !m_te_q) || (int_en[1] && !m_en_q && thr_empty);
        if (arm) m_thre = 1;
        else if (wr_thr || (rd_iir && c == 4'b0010)) m_thre = 0;
        m_te_q = thr_empty; m_en_q = int_en[1];
        if (!rx_nonempty || rx_push || rd_rbr) m_cnt = 0;
        else if (char_tick && m_cnt < TO_N) m_cnt++;
    endtask

    // One cycle: check before the edge, then update the model, clear strobes.
    task automatic step(string tag = "");
        #(CLK_P/4);
        compare(tag);
        @(posedge clk);
        m_update();
        @(negedge clk);
        err_evt = 0; ms_delta = 0; rx_push = 0; char_tick = 0;
        rd_iir = 0; rd_lsr = 0; rd_msr = 0; rd_rbr = 0; wr_thr = 0;
    endtask

    initial begin
        #(CLK_P*150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) step();
        rst_n = 1;
        step("R11");                          // R11: nothing pending after reset
        aux_out2 = 1;
        // R7: enable rising while empty arms; identification read clears
        int_en = 4'b0010; step("R7"); step("R7");
        rd_iir = 1; step("R7"); step("R7");
        // R7: write clears, register refill then empty re-arms
        thr_empty = 0; step(); thr_empty = 1; step("R7"); step("R7");
        wr_thr = 1; step("R7"); step("R7");
        // R3: masked line error does not show
        int_en = 4'b1011; err_evt = 4'b0100; step("R3"); step("R3");
        rd_lsr = 1; step("R4"); step("R4");
        // R2: all at once, serviced in order
        int_en = 4'b1111; err_evt = 4'b0001; ms_delta = 4'b0010;
        rx_avail = 1; thr_empty = 0; step("R2"); thr_empty = 1; step("R2");
        rd_lsr = 1; step("R2"); step("R2");
        rx_avail = 0; step("R2");
        rd_iir = 1; step("R2"); step("R8");
        rd_msr = 1; step("R8"); step("R1");
        // R4: event and read in the same cycle keeps pending
        err_evt = 4'b1000; rd_lsr = 1; step("R4"); step("R4");
        rd_lsr = 1; step("R4"); step("R4");
        // R6: timeout after TO_N ticks, restart by push, cleared by read
        rx_nonempty = 1;
        for (int i = 0; i < TO_N - 1; i++) begin char_tick = 1; step("R6"); end
        rx_push = 1; step("R6");
        for (int i = 0; i < TO_N; i++) begin char_tick = 1; step("R6"); end
        step("R6"); step("R6");
        rd_rbr = 1; step("R6"); step("R6");
        rx_nonempty = 0; step("R6");
        // R9: queue mode bits; R10: pin gate
        fifo_on = 1; step("R9"); fifo_deep = 1; step("R9");
        fifo_on = 0; step("R9"); fifo_on = 1;
        ms_delta = 4'b0001; step("R10"); aux_out2 = 0; step("R10");
        aux_out2 = 1; step("R10"); rd_msr = 1; step("R10"); step("R10");
        // Mixed traffic
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 15) == 0) err_evt = 4'($urandom);
            if ($urandom_range(0, 15) == 0) ms_delta = 4'($urandom);
            if ($urandom_range(0, 7) == 0) rx_avail = !rx_avail;
            if ($urandom_range(0, 9) == 0) rx_nonempty = !rx_nonempty;
            rx_push = ($urandom_range(0, 19) == 0);
            char_tick = ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 7) == 0) thr_empty = !thr_empty;
            if ($urandom_range(0, 31) == 0) int_en = 4'($urandom);
            if ($urandom_range(0, 63) == 0) aux_out2 = !aux_out2;
            if ($urandom_range(0, 63) == 0) fifo_deep = !fifo_deep;
            rd_iir = ($urandom_range(0, 3) == 0);
            rd_lsr = ($urandom_range(0, 7) == 0);
            rd_msr = ($urandom_range(0, 7) == 0);
            rd_rbr = ($urandom_range(0, 9) == 0);
            wr_thr = ($urandom_range(0, 9) == 0);
            if (i % 500 == 499) rst_n = 0; else rst_n = 1;
            step();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule